// File: doc/BRIEF.md
# DS3 FEAC Message Transceiver

This block carries Far-End Alarm and Control messages in the single FEAC overhead bit that each DS3 frame provides in C-bit parity mode. On the transmit side a 6-bit code is wrapped into a 16-bit framed word. That word goes out one bit per DS3 frame, one bit each time the framer strobes the FEAC slot. The word repeats for as long as the send request stays high. When no message is being sent, the slot carries 1s.

On the receive side the block takes one FEAC bit per frame strobe. It hunts for the word boundary and checks the framing bits. It then requires a code to repeat before it reports it. A new code is reported with a one-cycle pulse, and the code is held on a 6-bit output. The removal of an active code is reported with a one-cycle pulse of its own. Outside C-bit parity mode the transmitter sends 1s and the receiver freezes.

Top module: `feac_xcvr`

## Requirements
- R1: A sent word carries, in transmission order, eight 1s, one 0, code bits d0 through d5 (d0 = tx_code[0]), and a closing 0. Each accepted `tx_slot` strobe moves one bit, and `tx_bit` shows the bit for the current slot.
- R2: When no send request is active at a word boundary, `tx_bit` is 1 for every slot until a new word starts.
- R3: `tx_code` is sampled only at a word boundary. A word in progress finishes with the code it started with, and while `tx_send` stays high the word repeats back to back.
- R4: While `cbit_mode` is low, `tx_bit` is 1 and the transmitter returns to idle. `rx_strobe` and `rx_bit` are ignored: `rx_present` and `rx_code` hold, and no pulse is produced.
- R5: The receiver accepts a word only when the last 16 received bits are eight 1s, a 0, six code bits and a closing 0. A word whose closing bit is 1, or whose leading 1s are broken, counts as malformed.
- R6: After the same code arrives in two consecutive accepted words, `rx_new` pulses for one cycle, `rx_present` goes high, and `rx_code` shows the code. `rx_code` changes only together with `rx_new`.
- R7: An active code is cleared after two consecutive words that are malformed or carry another code. `rx_removed` then pulses for one cycle and `rx_present` drops. A single bad word followed by the active code again does not clear it.
- R8: When a different code clears the active one, the next word that carries that same code declares it valid.
- R9: After reset, `tx_bit` is 1, `rx_present`, `rx_new` and `rx_removed` are low, and `rx_code` is 0.
- R10: While the receiver is hunting, every 16 strobes without an accepted word count as one malformed word. A line of all 1s therefore clears an active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbit_mode | input | 1 | C-bit parity framing active; enables FEAC on both sides |
| tx_code | input | 6 | Code to send, d5..d0 |
| tx_send | input | 1 | Request to send `tx_code` continuously |
| tx_slot | input | 1 | Framer strobe: the FEAC transmit slot is taken this cycle |
| tx_bit | output | 1 | Bit for the current transmit slot |
| rx_strobe | input | 1 | Received FEAC bit is valid this cycle |
| rx_bit | input | 1 | Received FEAC bit |
| rx_code | output | 6 | Last code declared valid |
| rx_new | output | 1 | One-cycle pulse on a new valid declaration |
| rx_removed | output | 1 | One-cycle pulse when the active code is cleared |
| rx_present | output | 1 | A valid code is currently active |

## Verification
A transmit slot and a receive strobe can fall in the same cycle. The bench provokes this by looping `tx_bit` back into `rx_bit` and raising both strobes together. In that setup the bit the transmitter advances past is exactly the bit the receiver shifts in. The bench judges the result by the receiver events that a scoreboard expects from the transmitted codes. Those events are the declaration, the clearing, and the three-word change of code. The bench also lines up a code change on `tx_code` with a slot in the middle of a word. It checks that the rest of the word still carries the old code.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int FEAC_CODE_W  = 6;
  localparam int FEAC_ONES    = 8;
  localparam int FEAC_CONFIRM = 2;
  localparam int FEAC_CLEAR   = 2;
endpackage

// File: rtl/feac_tx.sv
module feac_tx #(
  parameter int CODE_W = feac_pkg::FEAC_CODE_W,
  parameter int ONES   = feac_pkg::FEAC_ONES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_mode,
  input  logic [CODE_W-1:0] tx_code,
  input  logic              tx_send,
  input  logic              tx_slot,
  output logic              tx_bit
);
  localparam int WORD_LEN = ONES + CODE_W + 2;
  localparam int IDX_W    = $clog2(WORD_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_LEN - 1);
  localparam logic [IDX_W-1:0] SEP  = IDX_W'(ONES);

  logic              busy_q, busy_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              wbit;

  // bit selected by the word pointer
  always_comb begin
    wbit = 1'b1;
    if (idx_q == SEP || idx_q == LAST) wbit = 1'b0;
    for (int k = 0; k < CODE_W; k++) begin
      if (idx_q == IDX_W'(ONES + 1 + k)) wbit = code_q[k];
    end
  end

  assign tx_bit = (cbit_mode && busy_q) ? wbit : 1'b1;

  always_comb begin
    busy_d = busy_q;
    code_d = code_q;
    idx_d  = idx_q;
    if (!cbit_mode) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (tx_slot) begin
      if (idx_q == '0) begin
        busy_d = tx_send;
        if (tx_send) begin
          code_d = tx_code;
          idx_d  = IDX_W'(1);
        end
      end else if (idx_q == LAST) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      code_q <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  AST_TX_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != '0) |=> $stable(code_q)); // R3
  AST_TX_WORD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cbit_mode && tx_slot && idx_q == LAST) |=> (idx_q == '0)); // R1
  AST_TX_MODE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cbit_mode |=> (!busy_q && idx_q == '0)); // R4
endmodule

// File: rtl/feac_rx_align.sv
module feac_rx_align #(
  parameter int CODE_W = feac_pkg::FEAC_CODE_W,
  parameter int ONES   = feac_pkg::FEAC_ONES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_mode,
  input  logic              rx_strobe,
  input  logic              rx_bit,
  output logic              evt_hit,
  output logic              evt_miss,
  output logic [CODE_W-1:0] evt_code
);
  localparam int WORD_LEN = ONES + CODE_W + 2;
  localparam int IDX_W    = $clog2(WORD_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_LEN - 1);

  logic [WORD_LEN-1:0] sr_q, sr_d, nsr;
  logic                locked_q, locked_d;
  logic [IDX_W-1:0]    cnt_q, cnt_d;
  logic                take, match, at_end;

  assign take   = cbit_mode && rx_strobe;
  assign nsr    = {sr_q[WORD_LEN-2:0], rx_bit};
  assign match  = (&nsr[WORD_LEN-1 -: ONES]) && !nsr[CODE_W+1] && !nsr[0];
  assign at_end = (cnt_q == LAST);

  // newest bit at index 0: d0 sits at CODE_W, dk at CODE_W-k
  always_comb begin
    for (int k = 0; k < CODE_W; k++) evt_code[k] = nsr[CODE_W-k];
  end

  assign evt_hit  = take && match && (!locked_q || at_end);
  assign evt_miss = take && at_end && !match;

  always_comb begin
    sr_d     = sr_q;
    locked_d = locked_q;
    cnt_d    = cnt_q;
    if (take) begin
      sr_d = nsr;
      if (evt_hit) begin
        locked_d = 1'b1;
        cnt_d    = '0;
      end else if (at_end) begin
        locked_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      locked_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sr_q     <= sr_d;
      locked_q <= locked_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_RX_LOCK_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> (locked_q && cnt_q == '0)); // R5
  AST_RX_MISS_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss |=> !locked_q); // R10
  AST_RX_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cbit_mode |=> ($stable(sr_q) && $stable(locked_q) && $stable(cnt_q))); // R4
endmodule

// File: rtl/feac_rx_qual.sv
module feac_rx_qual #(
  parameter int CODE_W  = feac_pkg::FEAC_CODE_W,
  parameter int CONFIRM = feac_pkg::FEAC_CONFIRM,
  parameter int CLEAR   = feac_pkg::FEAC_CLEAR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_hit,
  input  logic              evt_miss,
  input  logic [CODE_W-1:0] evt_code,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_new,
  output logic              rx_removed,
  output logic              rx_present
);
  localparam int HC_W = $clog2(CONFIRM + 1);
  localparam int MC_W = $clog2(CLEAR + 1);

  logic [CODE_W-1:0] cand_q, cand_d, act_code_q, act_code_d;
  logic [HC_W-1:0]   hcnt_q, hcnt_d;
  logic [MC_W-1:0]   mcnt_q, mcnt_d;
  logic              act_q, act_d, new_q, new_d, rem_q, rem_d;

  always_comb begin
    cand_d     = cand_q;
    hcnt_d     = hcnt_q;
    act_d      = act_q;
    act_code_d = act_code_q;
    mcnt_d     = mcnt_q;
    new_d      = 1'b0;
    rem_d      = 1'b0;
    // repetition tracking for the candidate code
    if (evt_hit) begin
      if (evt_code == cand_q && hcnt_q != '0) begin
        if (hcnt_q < HC_W'(CONFIRM)) hcnt_d = hcnt_q + 1'b1;
      end else begin
        cand_d = evt_code;
        hcnt_d = HC_W'(1);
      end
    end else if (evt_miss) begin
      hcnt_d = '0;
    end
    // declaration and clearing
    if (act_q) begin
      if (evt_hit && evt_code == act_code_q) begin
        mcnt_d = '0;
      end else if (evt_hit || evt_miss) begin
        if (mcnt_q == MC_W'(CLEAR - 1)) begin
          act_d  = 1'b0;
          mcnt_d = '0;
          rem_d  = 1'b1;
        end else begin
          mcnt_d = mcnt_q + 1'b1;
        end
      end
    end else if (evt_hit && hcnt_d >= HC_W'(CONFIRM)) begin
      act_d      = 1'b1;
      act_code_d = evt_code;
      mcnt_d     = '0;
      new_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q     <= '0;
      hcnt_q     <= '0;
      act_q      <= 1'b0;
      act_code_q <= '0;
      mcnt_q     <= '0;
      new_q      <= 1'b0;
      rem_q      <= 1'b0;
    end else begin
      cand_q     <= cand_d;
      hcnt_q     <= hcnt_d;
      act_q      <= act_d;
      act_code_q <= act_code_d;
      mcnt_q     <= mcnt_d;
      new_q      <= new_d;
      rem_q      <= rem_d;
    end
  end

  assign rx_code    = act_code_q;
  assign rx_new     = new_q;
  assign rx_removed = rem_q;
  assign rx_present = act_q;

  AST_QUAL_NEW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |=> !rx_new); // R6
  AST_QUAL_NEW_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |-> rx_present); // R6
  AST_QUAL_CODE_WITH_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_code) |-> rx_new); // R6
  AST_QUAL_REMOVED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_removed |-> (!rx_present && $past(rx_present))); // R7
endmodule

// File: rtl/feac_xcvr.sv
module feac_xcvr #(
  parameter int CODE_W  = feac_pkg::FEAC_CODE_W,
  parameter int ONES    = feac_pkg::FEAC_ONES,
  parameter int CONFIRM = feac_pkg::FEAC_CONFIRM,
  parameter int CLEAR   = feac_pkg::FEAC_CLEAR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbit_mode,
  input  logic [CODE_W-1:0] tx_code,
  input  logic              tx_send,
  input  logic              tx_slot,
  output logic              tx_bit,
  input  logic              rx_strobe,
  input  logic              rx_bit,
  output logic [CODE_W-1:0] rx_code,
  output logic              rx_new,
  output logic              rx_removed,
  output logic              rx_present
);
  logic              evt_hit, evt_miss;
  logic [CODE_W-1:0] evt_code;

  feac_tx #(.CODE_W(CODE_W), .ONES(ONES)) u_tx (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .tx_code(tx_code),
    .tx_send(tx_send), .tx_slot(tx_slot), .tx_bit(tx_bit)
  );

  feac_rx_align #(.CODE_W(CODE_W), .ONES(ONES)) u_align (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .rx_strobe(rx_strobe),
    .rx_bit(rx_bit), .evt_hit(evt_hit), .evt_miss(evt_miss), .evt_code(evt_code)
  );

  feac_rx_qual #(.CODE_W(CODE_W), .CONFIRM(CONFIRM), .CLEAR(CLEAR)) u_qual (
    .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .evt_miss(evt_miss),
    .evt_code(evt_code), .rx_code(rx_code), .rx_new(rx_new),
    .rx_removed(rx_removed), .rx_present(rx_present)
  );

  AST_TOP_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_new && rx_removed)); // R7
endmodule

// File: tb/feac_xcvr_bench.sv
module feac_xcvr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cbit_mode = 1'b0;
  logic [5:0] tx_code = '0;
  logic       tx_send = 1'b0;
  logic       tx_slot = 1'b0;
  logic       tx_bit;
  logic       rx_strobe = 1'b0;
  logic       rx_drv = 1'b1;
  logic       loop_en = 1'b0;
  logic       rx_bit;
  logic [5:0] rx_code;
  logic       rx_new, rx_removed, rx_present;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [6:0] exp_q[$]; // {1 = new / 0 = removed, code}

  always #2.5 clk = ~clk;
  assign rx_bit = loop_en ? tx_bit : rx_drv;

  feac_xcvr u_feac_xcvr (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .tx_code(tx_code),
    .tx_send(tx_send), .tx_slot(tx_slot), .tx_bit(tx_bit),
    .rx_strobe(rx_strobe), .rx_bit(rx_bit), .rx_code(rx_code),
    .rx_new(rx_new), .rx_removed(rx_removed), .rx_present(rx_present)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic word_bit(input int i, input logic [5:0] c);
    if (i < 8) return 1'b1;
    if (i == 8 || i == 15) return 1'b0;
    return c[i-9];
  endfunction

  // one strobe: both strobes in loopback, receive only otherwise
  task automatic tick(input logic slot, input logic b, output logic seen);
    rx_drv    = b;
    tx_slot   = slot;
    rx_strobe = 1'b1;
    seen      = tx_bit;
    @(negedge clk);
    tx_slot   = 1'b0;
    rx_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_word(input logic [5:0] c, input int flip);
    logic s;
    for (int i = 0; i < 16; i++) tick(1'b0, word_bit(i, c) ^ (i == flip), s);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (rx_new || rx_removed)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6_R7 unexpected event", {rx_new, rx_code}, 0);
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        check(rx_new == e[6], "R6_R7 event kind", rx_new, e[6]);
        if (e[6]) check(rx_code == e[5:0], "R6 declared code", rx_code, e[5:0]);
        else check(!rx_present, "R7 present cleared", rx_present, 0);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, run incomplete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(tx_bit == 1'b1, "R9 tx_bit", tx_bit, 1);
    check(!rx_present, "R9 rx_present", rx_present, 0);
    check(!rx_new && !rx_removed, "R9 pulses", {rx_new, rx_removed}, 0);
    check(rx_code == 6'h00, "R9 rx_code", rx_code, 0);

    // R2 idle ones in loopback
    cbit_mode = 1'b1;
    loop_en   = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin tick(1'b1, 1'b0, s); if (s !== 1'b1) bad++; end
    check(bad == 0, "R2 idle slots", bad, 0);

    // R1 word format, R6 declaration via loopback
    exp_q.push_back({1'b1, 6'h2D});
    tx_code = 6'h2D;
    tx_send = 1'b1;
    bad = 0;
    for (int i = 0; i < 16; i++) begin tick(1'b1, 1'b0, s); if (s !== word_bit(i, 6'h2D)) bad++; end
    check(bad == 0, "R1 word bits 2D", bad, 0);
    bad = 0;
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 16; i++) begin tick(1'b1, 1'b0, s); if (s !== word_bit(i, 6'h2D)) bad++; end
    check(bad == 0, "R3 word repeats", bad, 0);
    check(rx_present && rx_code == 6'h2D, "R6 present and code", {rx_present, rx_code}, {1'b1, 6'h2D});

    // R3 code change mid-word; R8 replacement after removal
    exp_q.push_back({1'b0, 6'h00});
    exp_q.push_back({1'b1, 6'h0A});
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, s);
    tx_code = 6'h0A;
    bad = 0;
    for (int i = 5; i < 16; i++) begin tick(1'b1, 1'b0, s); if (s !== word_bit(i, 6'h2D)) bad++; end
    check(bad == 0, "R3 word finishes with old code", bad, 0);
    bad = 0;
    for (int w = 0; w < 3; w++)
      for (int i = 0; i < 16; i++) begin tick(1'b1, 1'b0, s); if (s !== word_bit(i, 6'h0A)) bad++; end
    check(bad == 0, "R1 word bits 0A", bad, 0);
    check(rx_present && rx_code == 6'h0A, "R8 new code declared", {rx_present, rx_code}, {1'b1, 6'h0A});

    // R3 drop request mid-word, R2 idle after, R10 ones clear the code
    exp_q.push_back({1'b0, 6'h00});
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, s);
    tx_send = 1'b0;
    bad = 0;
    for (int i = 4; i < 16; i++) begin tick(1'b1, 1'b0, s); if (s !== word_bit(i, 6'h0A)) bad++; end
    check(bad == 0, "R3 last word completes", bad, 0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin tick(1'b1, 1'b0, s); if (s !== 1'b1) bad++; end
    check(bad == 0, "R2 idle after request drops", bad, 0);
    check(!rx_present, "R10 all ones clears code", rx_present, 0);

    // direct receive: boundary codes and R8
    loop_en = 1'b0;
    exp_q.push_back({1'b1, 6'h00});
    rx_word(6'h00, -1);
    check(!rx_present, "R6 one word not enough", rx_present, 0);
    rx_word(6'h00, -1);
    check(rx_present && rx_code == 6'h00, "R6 code 00", {rx_present, rx_code}, {1'b1, 6'h00});
    exp_q.push_back({1'b0, 6'h00});
    exp_q.push_back({1'b1, 6'h3F});
    rx_word(6'h3F, -1);
    check(rx_present && rx_code == 6'h00, "R7 one other word keeps code", {rx_present, rx_code}, {1'b1, 6'h00});
    rx_word(6'h3F, -1);
    check(!rx_present, "R7 second other word clears", rx_present, 0);
    rx_word(6'h3F, -1);
    check(rx_present && rx_code == 6'h3F, "R8 code 3F after removal", {rx_present, rx_code}, {1'b1, 6'h3F});

    // R5 closing bit 1 makes a word malformed
    exp_q.push_back({1'b0, 6'h00});
    rx_word(6'h3F, 15);
    rx_word(6'h3F, 15);
    check(!rx_present, "R5 bad closing bit clears", rx_present, 0);

    // R5 hunt through leading garbage
    exp_q.push_back({1'b1, 6'h11});
    tick(1'b0, 1'b0, s); tick(1'b0, 1'b1, s); tick(1'b0, 1'b0, s);
    tick(1'b0, 1'b1, s); tick(1'b0, 1'b1, s);
    rx_word(6'h11, -1);
    rx_word(6'h11, -1);
    check(rx_present && rx_code == 6'h11, "R5 realign after garbage", {rx_present, rx_code}, {1'b1, 6'h11});
    // R7 single broken word followed by the active code keeps it
    rx_word(6'h11, 3);
    rx_word(6'h11, -1);
    rx_word(6'h11, 3);
    rx_word(6'h11, -1);
    check(rx_present && rx_code == 6'h11, "R7 isolated bad words", {rx_present, rx_code}, {1'b1, 6'h11});

    // R4 mode off
    cbit_mode = 1'b0;
    tx_code   = 6'h15;
    tx_send   = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin tick(1'b1, 1'b0, s); if (s !== 1'b1) bad++; end
    check(bad == 0, "R4 tx ones with mode off", bad, 0);
    for (int i = 0; i < 3; i++) rx_word(6'h22, 15);
    check(rx_present && rx_code == 6'h11, "R4 rx ignored with mode off", {rx_present, rx_code}, {1'b1, 6'h11});

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6_R7 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule